// File: doc/BRIEF.md
# Stream Space Synchronization Unit

This unit sits inside the shell of a multitasking coprocessor. It keeps one space counter per local stream. For a producer that counter is free room in the buffer; for a consumer it is available data. The coprocessor asks whether a port has at least n bytes through an inquiry, and the answer comes back in the same cycle. It hands n bytes over to the other end of the stream through a commit. A commit lowers the local counter at once and queues a message with the stream's global id and the byte count. Queued messages go out on a unidirectional, registered token ring.

Messages that arrive from the ring are handled by id. When the id matches a local stream, the message adds its byte count to that stream's counter and leaves the ring there. Any other message passes to the next stage one cycle later. The two ends of one buffer live on different shells and are configured with the same global id. Each end therefore consumes only the messages its partner sends.

A register-style port writes and reads the stream table. Each entry holds a buffer base, a buffer size, a space count and a global id. The ring delay only changes how soon space shows up at the other end. It never changes the outcome of an inquiry or a commit.

Top module: `ssync_unit`

## Requirements
- R1: After reset the ring output is empty, the error flag and all blocked flags are 0, commits are accepted (`com_rdy_o`=1), and every table field reads 0.
- R2: The table address is {stream index, field code}, with the field code in the two low bits: 0 = buffer base, 1 = buffer size, 2 = space count, 3 = global id. A write updates that field on the next edge, and `cfg_rdata_o` returns the addressed field zero-extended, combinationally.
- R3: `inq_ok_o` is 1 in the same cycle exactly when `inq_vld_i` is 1 and the addressed port's space is at least `inq_bytes_i`. An inquiry never changes a space count.
- R4: A port's blocked flag becomes 1 after an inquiry on it fails and 0 after an inquiry on it succeeds.
- R5: An accepted commit of n bytes (n not above the current space) subtracts n from the port's space. It also sends a ring message carrying the port's global id and n, and local messages leave in commit order.
- R6: A valid ring input whose id equals a local stream's global id adds its count to the lowest-indexed such stream and is not passed on.
- R7: A valid ring input that matches no local stream appears unchanged on the ring output one cycle later and takes precedence over waiting local messages.
- R8: A waiting local message goes out in the cycle after a matching ring message is consumed, reusing the freed slot.
- R9: With FIFO_DEPTH local messages waiting, `com_rdy_o` is 0 and a commit presented then has no effect on space or on the ring.
- R10: A commit and a matching ring message for the same stream in one cycle are both applied as one net change.
- R11: A commit of more bytes than the port's space leaves the space unchanged, sends nothing, and sets `err_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | SW+2 | {stream index, field code} |
| cfg_wdata_i | input | CFG_W | Table write data |
| cfg_rdata_o | output | CFG_W | Addressed table field, zero-extended |
| inq_vld_i | input | 1 | Space inquiry request |
| inq_port_i | input | SW | Inquired stream |
| inq_bytes_i | input | CNT_W | Requested byte count |
| inq_ok_o | output | 1 | Enough space for the inquiry |
| blocked_o | output | N_STREAMS | Per-stream blocked flags |
| com_vld_i | input | 1 | Commit request |
| com_port_i | input | SW | Committed stream |
| com_bytes_i | input | CNT_W | Committed byte count |
| com_rdy_o | output | 1 | Commit can be taken |
| err_o | output | 1 | Sticky over-commit error |
| ring_in_vld_i | input | 1 | Ring input slot occupied |
| ring_in_gid_i | input | GID_W | Ring input global id |
| ring_in_cnt_i | input | CNT_W | Ring input byte count |
| ring_out_vld_o | output | 1 | Ring output slot occupied |
| ring_out_gid_o | output | GID_W | Ring output global id |
| ring_out_cnt_o | output | CNT_W | Ring output byte count |

## Verification
The hardest state to reach from the ports is a full local message queue. Filling it needs the ring to stay occupied by foreign traffic for several cycles in a row while commits keep arriving. The bench drives eight back-to-back non-matching ring messages and commits once per cycle during that window. The fifth commit then meets `com_rdy_o` low, and the scoreboard expects all forwarded messages before the drained local ones. A second sequence consumes a matching message while one local message waits, and checks that the slot is reused in the very next cycle.

// File: rtl/ssync_pkg.sv
package ssync_pkg;
  localparam int unsigned FLD_W = 2;

  typedef enum logic [FLD_W-1:0] {
    FLD_BASE  = 2'd0,
    FLD_SIZE  = 2'd1,
    FLD_SPACE = 2'd2,
    FLD_GID   = 2'd3
  } fld_e;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ssync_msg_fifo.sv
module ssync_msg_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = ssync_pkg::idx_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/ssync_table.sv
module ssync_table
  import ssync_pkg::*;
#(
  parameter int unsigned N_STREAMS = 4,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned GID_W     = 4,
  parameter int unsigned CFG_W     = 16,
  localparam int unsigned SW       = idx_w(N_STREAMS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cfg_we_i,
  input  logic [SW-1:0]                     cfg_sel_i,
  input  logic [FLD_W-1:0]                  cfg_fld_i,
  input  logic [CFG_W-1:0]                  cfg_wdata_i,
  output logic [CFG_W-1:0]                  cfg_rdata_o,
  input  logic                              inq_vld_i,
  input  logic [SW-1:0]                     inq_port_i,
  input  logic [CNT_W-1:0]                  inq_bytes_i,
  output logic                              inq_ok_o,
  input  logic                              com_take_i,
  input  logic [SW-1:0]                     com_port_i,
  input  logic [CNT_W-1:0]                  com_bytes_i,
  output logic                              com_fits_o,
  input  logic                              add_vld_i,
  input  logic [SW-1:0]                     add_sel_i,
  input  logic [CNT_W-1:0]                  add_bytes_i,
  output logic [N_STREAMS-1:0][CNT_W-1:0]   space_o,
  output logic [N_STREAMS-1:0][GID_W-1:0]   gid_o,
  output logic [N_STREAMS-1:0]              blocked_o,
  output logic                              err_o
);
  logic [N_STREAMS-1:0][ADDR_W-1:0] base_q;
  logic [N_STREAMS-1:0][CNT_W-1:0]  size_q;
  logic [N_STREAMS-1:0][CNT_W-1:0]  space_q;
  logic [N_STREAMS-1:0][GID_W-1:0]  gid_q;
  logic [N_STREAMS-1:0]             blk_q;
  logic                             err_q;
  logic                             inq_ge;
  fld_e                             fld;

  assign fld        = fld_e'(cfg_fld_i);
  assign inq_ge     = (space_q[inq_port_i] >= inq_bytes_i);
  assign inq_ok_o   = inq_vld_i & inq_ge;
  assign com_fits_o = (com_bytes_i <= space_q[com_port_i]);
  assign space_o    = space_q;
  assign gid_o      = gid_q;
  assign blocked_o  = blk_q;
  assign err_o      = err_q;

  always_comb begin
    unique case (fld)
      FLD_BASE:  cfg_rdata_o = CFG_W'(base_q[cfg_sel_i]);
      FLD_SIZE:  cfg_rdata_o = CFG_W'(size_q[cfg_sel_i]);
      FLD_SPACE: cfg_rdata_o = CFG_W'(space_q[cfg_sel_i]);
      default:   cfg_rdata_o = CFG_W'(gid_q[cfg_sel_i]);
    endcase
  end

  for (genvar i = 0; i < N_STREAMS; i++) begin : g_ent
    logic             wr_hit, sub, add;
    logic [CNT_W-1:0] sub_n, add_n;

    assign wr_hit = cfg_we_i & (cfg_sel_i == SW'(i));
    assign sub    = com_take_i & com_fits_o & (com_port_i == SW'(i));
    assign add    = add_vld_i & (add_sel_i == SW'(i));
    assign sub_n  = sub ? com_bytes_i : '0;
    assign add_n  = add ? add_bytes_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[i]  <= '0;
        size_q[i]  <= '0;
        space_q[i] <= '0;
        gid_q[i]   <= '0;
        blk_q[i]   <= 1'b0;
      end else begin
        if (wr_hit && fld == FLD_BASE) base_q[i] <= ADDR_W'(cfg_wdata_i);
        if (wr_hit && fld == FLD_SIZE) size_q[i] <= CNT_W'(cfg_wdata_i);
        if (wr_hit && fld == FLD_GID)  gid_q[i]  <= GID_W'(cfg_wdata_i);
        // configuration wins over traffic in the same cycle
        if (wr_hit && fld == FLD_SPACE) space_q[i] <= CNT_W'(cfg_wdata_i);
        else                            space_q[i] <= space_q[i] - sub_n + add_n;
        if (inq_vld_i && inq_port_i == SW'(i)) blk_q[i] <= ~inq_ge;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       err_q <= 1'b0;
    else if (com_take_i && !com_fits_o) err_q <= 1'b1;
  end
endmodule

// File: rtl/ssync_ring_stage.sv
module ssync_ring_stage
  import ssync_pkg::*;
#(
  parameter int unsigned N_STREAMS = 4,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned GID_W     = 4,
  localparam int unsigned SW       = idx_w(N_STREAMS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            in_vld_i,
  input  logic [GID_W-1:0]                in_gid_i,
  input  logic [CNT_W-1:0]                in_cnt_i,
  input  logic [N_STREAMS-1:0][GID_W-1:0] gid_tab_i,
  input  logic                            loc_vld_i,
  input  logic [GID_W-1:0]                loc_gid_i,
  input  logic [CNT_W-1:0]                loc_cnt_i,
  output logic                            loc_pop_o,
  output logic                            hit_o,
  output logic [SW-1:0]                   hit_idx_o,
  output logic                            out_vld_o,
  output logic [GID_W-1:0]                out_gid_o,
  output logic [CNT_W-1:0]                out_cnt_o
);
  logic fwd;

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = N_STREAMS - 1; i >= 0; i--) begin
      if (in_vld_i && gid_tab_i[i] == in_gid_i) begin
        hit_o     = 1'b1;
        hit_idx_o = SW'(i);
      end
    end
  end

  assign fwd       = in_vld_i & ~hit_o;
  assign loc_pop_o = loc_vld_i & ~fwd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o <= 1'b0;
      out_gid_o <= '0;
      out_cnt_o <= '0;
    end else if (fwd) begin
      out_vld_o <= 1'b1;
      out_gid_o <= in_gid_i;
      out_cnt_o <= in_cnt_i;
    end else if (loc_pop_o) begin
      out_vld_o <= 1'b1;
      out_gid_o <= loc_gid_i;
      out_cnt_o <= loc_cnt_i;
    end else begin
      out_vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ssync_unit.sv
module ssync_unit
  import ssync_pkg::*;
#(
  parameter int unsigned N_STREAMS  = 4,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned GID_W      = 4,
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned SW        = idx_w(N_STREAMS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [SW+FLD_W-1:0]   cfg_addr_i,
  input  logic [CFG_W-1:0]      cfg_wdata_i,
  output logic [CFG_W-1:0]      cfg_rdata_o,
  input  logic                  inq_vld_i,
  input  logic [SW-1:0]         inq_port_i,
  input  logic [CNT_W-1:0]      inq_bytes_i,
  output logic                  inq_ok_o,
  output logic [N_STREAMS-1:0]  blocked_o,
  input  logic                  com_vld_i,
  input  logic [SW-1:0]         com_port_i,
  input  logic [CNT_W-1:0]      com_bytes_i,
  output logic                  com_rdy_o,
  output logic                  err_o,
  input  logic                  ring_in_vld_i,
  input  logic [GID_W-1:0]      ring_in_gid_i,
  input  logic [CNT_W-1:0]      ring_in_cnt_i,
  output logic                  ring_out_vld_o,
  output logic [GID_W-1:0]      ring_out_gid_o,
  output logic [CNT_W-1:0]      ring_out_cnt_o
);
  localparam int unsigned MSG_W = GID_W + CNT_W;

  logic [N_STREAMS-1:0][CNT_W-1:0] space_tab;
  logic [N_STREAMS-1:0][GID_W-1:0] gid_tab;
  logic                            com_take, com_fits, push;
  logic                            q_empty, q_full, q_pop;
  logic [MSG_W-1:0]                q_wdata, q_rdata;
  logic                            hit;
  logic [SW-1:0]                   hit_idx;

  assign com_rdy_o = ~q_full;
  assign com_take  = com_vld_i & ~q_full;
  assign push      = com_take & com_fits;
  assign q_wdata   = {gid_tab[com_port_i], com_bytes_i};

  ssync_table #(
    .N_STREAMS(N_STREAMS), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .GID_W(GID_W), .CFG_W(CFG_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_addr_i[SW+FLD_W-1:FLD_W]),
    .cfg_fld_i   (cfg_addr_i[FLD_W-1:0]),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .inq_vld_i   (inq_vld_i),
    .inq_port_i  (inq_port_i),
    .inq_bytes_i (inq_bytes_i),
    .inq_ok_o    (inq_ok_o),
    .com_take_i  (com_take),
    .com_port_i  (com_port_i),
    .com_bytes_i (com_bytes_i),
    .com_fits_o  (com_fits),
    .add_vld_i   (hit),
    .add_sel_i   (hit_idx),
    .add_bytes_i (ring_in_cnt_i),
    .space_o     (space_tab),
    .gid_o       (gid_tab),
    .blocked_o   (blocked_o),
    .err_o       (err_o)
  );

  ssync_msg_fifo #(.DEPTH(FIFO_DEPTH), .W(MSG_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (q_wdata),
    .pop_i   (q_pop),
    .data_o  (q_rdata),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  ssync_ring_stage #(.N_STREAMS(N_STREAMS), .CNT_W(CNT_W), .GID_W(GID_W)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (ring_in_vld_i),
    .in_gid_i  (ring_in_gid_i),
    .in_cnt_i  (ring_in_cnt_i),
    .gid_tab_i (gid_tab),
    .loc_vld_i (~q_empty),
    .loc_gid_i (q_rdata[MSG_W-1:CNT_W]),
    .loc_cnt_i (q_rdata[CNT_W-1:0]),
    .loc_pop_o (q_pop),
    .hit_o     (hit),
    .hit_idx_o (hit_idx),
    .out_vld_o (ring_out_vld_o),
    .out_gid_o (ring_out_gid_o),
    .out_cnt_o (ring_out_cnt_o)
  );
endmodule

// File: rtl/ssync_unit_chk.sv
module ssync_unit_chk #(
  parameter int unsigned N_STREAMS = 4,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned GID_W     = 4,
  localparam int unsigned SW       = ssync_pkg::idx_w(N_STREAMS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            cfg_we_i,
  input logic                            inq_vld_i,
  input logic [SW-1:0]                   inq_port_i,
  input logic                            inq_ok_o,
  input logic [N_STREAMS-1:0]            blocked_o,
  input logic                            com_vld_i,
  input logic [SW-1:0]                   com_port_i,
  input logic [CNT_W-1:0]                com_bytes_i,
  input logic                            com_rdy_o,
  input logic                            err_o,
  input logic                            ring_in_vld_i,
  input logic [GID_W-1:0]                ring_in_gid_i,
  input logic [CNT_W-1:0]                ring_in_cnt_i,
  input logic                            ring_out_vld_o,
  input logic [GID_W-1:0]                ring_out_gid_o,
  input logic [CNT_W-1:0]                ring_out_cnt_o,
  input logic                            hit,
  input logic [N_STREAMS-1:0][CNT_W-1:0] space_tab
);
  AST_INQ_KEEPS_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inq_vld_i && !com_vld_i && !ring_in_vld_i && !cfg_we_i |=> $stable(space_tab)); // R3

  AST_BLOCKED_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inq_vld_i && !inq_ok_o |=> blocked_o[$past(inq_port_i)]); // R4

  AST_COMMIT_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_vld_i && com_rdy_o && com_bytes_i <= space_tab[com_port_i] && !ring_in_vld_i && !cfg_we_i
    |=> space_tab[$past(com_port_i)] == $past(space_tab[com_port_i]) - $past(com_bytes_i)); // R5

  AST_FORWARD_FOREIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_in_vld_i && !hit |=> ring_out_vld_o && ring_out_gid_o == $past(ring_in_gid_i)
                              && ring_out_cnt_o == $past(ring_in_cnt_i)); // R7

  AST_STALL_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_vld_i && !com_rdy_o && !ring_in_vld_i && !cfg_we_i |=> $stable(space_tab)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R11
endmodule

bind ssync_unit ssync_unit_chk #(
  .N_STREAMS(N_STREAMS), .CNT_W(CNT_W), .GID_W(GID_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_we_i       (cfg_we_i),
  .inq_vld_i      (inq_vld_i),
  .inq_port_i     (inq_port_i),
  .inq_ok_o       (inq_ok_o),
  .blocked_o      (blocked_o),
  .com_vld_i      (com_vld_i),
  .com_port_i     (com_port_i),
  .com_bytes_i    (com_bytes_i),
  .com_rdy_o      (com_rdy_o),
  .err_o          (err_o),
  .ring_in_vld_i  (ring_in_vld_i),
  .ring_in_gid_i  (ring_in_gid_i),
  .ring_in_cnt_i  (ring_in_cnt_i),
  .ring_out_vld_o (ring_out_vld_o),
  .ring_out_gid_o (ring_out_gid_o),
  .ring_out_cnt_o (ring_out_cnt_o),
  .hit            (hit),
  .space_tab      (space_tab)
);

// File: tb/ssync_unit_test.sv
`timescale 1ns/1ps
module ssync_unit_test;
  localparam int unsigned N = 4, CW = 16, GW = 4, FW = 16, DEPTH = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_we = 0;
  logic [3:0]    cfg_addr = '0;
  logic [FW-1:0] cfg_wdata = '0, cfg_rdata;
  logic          inq_vld = 0, inq_ok;
  logic [1:0]    inq_port = '0;
  logic [CW-1:0] inq_bytes = '0;
  logic [N-1:0]  blocked;
  logic          com_vld = 0, com_rdy, err;
  logic [1:0]    com_port = '0;
  logic [CW-1:0] com_bytes = '0;
  logic          rin_vld = 0, rout_vld;
  logic [GW-1:0] rin_gid = '0, rout_gid;
  logic [CW-1:0] rin_cnt = '0, rout_cnt;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [GW+CW-1:0] exp_q[$];

  always #4 clk = ~clk;

  ssync_unit #(.N_STREAMS(N), .CNT_W(CW), .GID_W(GW), .CFG_W(FW), .FIFO_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .inq_vld_i(inq_vld), .inq_port_i(inq_port), .inq_bytes_i(inq_bytes), .inq_ok_o(inq_ok),
    .blocked_o(blocked),
    .com_vld_i(com_vld), .com_port_i(com_port), .com_bytes_i(com_bytes), .com_rdy_o(com_rdy),
    .err_o(err),
    .ring_in_vld_i(rin_vld), .ring_in_gid_i(rin_gid), .ring_in_cnt_i(rin_cnt),
    .ring_out_vld_o(rout_vld), .ring_out_gid_o(rout_gid), .ring_out_cnt_o(rout_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: every ring output message is popped from the scoreboard
  always @(negedge clk) begin
    if (rst_n && rout_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5/R6/R7 ring: actual=%0d:%0d expected=none", rout_gid, rout_cnt);
      end else begin
        logic [GW+CW-1:0] e;
        e = exp_q.pop_front();
        if ({rout_gid, rout_cnt} != e) begin
          errors++;
          $display("FAIL R5/R7 ring: actual=%0d:%0d expected=%0d:%0d",
                   rout_gid, rout_cnt, e[GW+CW-1:CW], e[CW-1:0]);
        end
      end
    end
  end

  task automatic cfg_wr(input int s, input int f, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {s[1:0], f[1:0]}; cfg_wdata = FW'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_chk(input string req, input int s, input int f, input int exp);
    cfg_addr = {s[1:0], f[1:0]};
    #1 check(req, int'(cfg_rdata), exp);
  endtask

  task automatic inquire(input string req, input int p, input int n, input bit exp_ok);
    @(negedge clk);
    inq_vld = 1; inq_port = p[1:0]; inq_bytes = CW'(n);
    #1 check(req, int'(inq_ok), int'(exp_ok));
    @(negedge clk);
    inq_vld = 0;
  endtask

  task automatic commit(input int p, input int n, input int gid, input bit expect_msg);
    @(negedge clk);
    com_vld = 1; com_port = p[1:0]; com_bytes = CW'(n);
    if (expect_msg) exp_q.push_back({GW'(gid), CW'(n)});
    @(negedge clk);
    com_vld = 0;
  endtask

  task automatic ring_send(input int g, input int c, input bit fwd);
    @(negedge clk);
    rin_vld = 1; rin_gid = GW'(g); rin_cnt = CW'(c);
    if (fwd) exp_q.push_back({GW'(g), CW'(c)});
    @(negedge clk);
    rin_vld = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ring_out_vld", int'(rout_vld), 0);
    check("R1 err", int'(err), 0);
    check("R1 blocked", int'(blocked), 0);
    check("R1 com_rdy", int'(com_rdy), 1);
    cfg_chk("R1 space0", 0, 2, 0);
    rst_n = 1;
    // R2 table: field 0 base, 1 size, 2 space, 3 gid
    cfg_wr(0, 0, 'h1000); cfg_wr(0, 1, 256); cfg_wr(0, 2, 100); cfg_wr(0, 3, 3);
    cfg_wr(1, 2, 0);  cfg_wr(1, 3, 5);
    cfg_wr(2, 2, 40); cfg_wr(2, 3, 9);
    cfg_wr(3, 2, 0);  cfg_wr(3, 3, 12);
    cfg_chk("R2 base0", 0, 0, 'h1000);
    cfg_chk("R2 size0", 0, 1, 256);
    cfg_chk("R2 space2", 2, 2, 40);
    cfg_chk("R2 gid1", 1, 3, 5);
    // R3 / R4
    inquire("R3 inq exact", 0, 100, 1);
    inquire("R3 inq over", 0, 101, 0);
    check("R4 blocked set", int'(blocked[0]), 1);
    cfg_chk("R3 space unchanged", 0, 2, 100);
    inquire("R3 inq ok", 0, 60, 1);
    check("R4 blocked cleared", int'(blocked[0]), 0);
    // R5 commits
    commit(0, 30, 3, 1);
    commit(2, 15, 9, 1);
    cfg_chk("R5 space0", 0, 2, 70);
    cfg_chk("R5 space2", 2, 2, 25);
    // R6 matching ring message, not forwarded
    ring_send(5, 20, 0);
    cfg_chk("R6 space1", 1, 2, 20);
    // R7 foreign message forwarded
    ring_send(7, 44, 1);
    // R10 net update
    @(negedge clk);
    com_vld = 1; com_port = 0; com_bytes = 10; exp_q.push_back({GW'(3), CW'(10)});
    rin_vld = 1; rin_gid = 3; rin_cnt = 25;
    @(negedge clk);
    com_vld = 0; rin_vld = 0;
    cfg_chk("R10 space0 net", 0, 2, 85);
    // R11 over-commit
    commit(1, 50, 5, 0);
    check("R11 err set", int'(err), 1);
    cfg_chk("R11 space1 kept", 1, 2, 20);
    repeat (4) @(negedge clk);
    check("R11 err sticky", int'(err), 1);
    // R9 stall: ring busy with foreign traffic, queue fills
    for (int k = 0; k < 8; k++) exp_q.push_back({GW'(14), CW'(k + 1)});
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rin_vld = 1; rin_gid = 14; rin_cnt = CW'(k + 1);
      com_vld = 0;
      if (k < 5) begin
        #1 check("R9 com_rdy", int'(com_rdy), (k < 4) ? 1 : 0);
        com_vld = 1; com_port = 0; com_bytes = 1;
      end
    end
    @(negedge clk);
    rin_vld = 0; com_vld = 0;
    for (int k = 0; k < 4; k++) exp_q.push_back({GW'(3), CW'(1)});
    repeat (8) @(negedge clk);
    cfg_chk("R9 space0 after stall", 0, 2, 81);
    check("R9 com_rdy back", int'(com_rdy), 1);
    // R8 freed slot reused
    @(negedge clk);
    rin_vld = 1; rin_gid = 14; rin_cnt = 99; exp_q.push_back({GW'(14), CW'(99)});
    com_vld = 1; com_port = 2; com_bytes = 5; exp_q.push_back({GW'(9), CW'(5)});
    @(negedge clk);
    com_vld = 0; rin_gid = 5; rin_cnt = 2;
    @(negedge clk);
    rin_vld = 0;
    check("R8 slot reused vld", int'(rout_vld), 1);
    check("R8 slot reused gid", int'(rout_gid), 9);
    cfg_chk("R8 space1", 1, 2, 22);
    repeat (4) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule